// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block decides whether a conditional branch is taken. It takes a 4-bit condition selector and the four status flags left by the previous arithmetic operation: negative (N), zero (Z), overflow (V) and carry (C). It drives a single taken/not-taken bit. The conditions cover three groups. The first tests a single flag. The second gives unsigned magnitude orderings built from C and Z. The third gives signed magnitude orderings built from N XOR V, with Z added where equality matters.

The unit is purely combinational and holds no state. A sequencer places it between the flag register and the next-address multiplexer, so that the decision follows the flags in the same cycle. Selector codes come in pairs, and bit 0 of the selector inverts the sense of the pair.

Top module: `branch_cond_eval`

## Requirements
- R1: Code 0 (always) takes the branch for every flag value, and code 1 (never) takes it for no flag value.
- R2: Code 4 is taken when C = 0, and code 5 is taken when C = 1.
- R3: Code 6 is taken when Z = 0, and code 7 is taken when Z = 1.
- R4: Code 10 is taken when N = 0, and code 11 is taken when N = 1.
- R5: Code 8 is taken when V = 0, and code 9 is taken when V = 1.
- R6: Code 2 (unsigned higher) is taken when (C OR Z) = 0, and code 3 (unsigned lower-or-same) is taken when (C OR Z) = 1.
- R7: Code 12 (signed greater-or-equal) is taken when (N XOR V) = 0, and code 13 (signed less) is taken when (N XOR V) = 1.
- R8: Code 14 (signed greater) is taken when (Z OR (N XOR V)) = 0, and code 15 (signed less-or-equal) is taken when (Z OR (N XOR V)) = 1.
- R9: For any flags, the two codes that differ only in bit 0 give opposite results.
- R10: The output depends only on the present inputs. A change of any input shows on take_o without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_i | input | 4 | Branch condition selector |
| n_i | input | 1 | Negative flag |
| z_i | input | 1 | Zero flag |
| v_i | input | 1 | Overflow flag |
| c_i | input | 1 | Carry flag |
| take_o | output | 1 | High when the selected condition holds |

## Verification
The block holds no state, so a fault in its decode shows on take_o as soon as the faulty selector and flag combination is applied, with no latency. A swapped pair, a wrong flag term or a lost inversion bit each corrupts a fixed subset of the 256 input combinations. Every one of those combinations is driven and compared, and random sequences then check that the output tracks input changes between clock edges.

// File: rtl/brc_pkg.sv
package brc_pkg;
    parameter int CODE_W = 4;
    localparam int PAIRS = 2 ** (CODE_W - 1);
    localparam int PAIR_W = CODE_W - 1;

    typedef enum logic [CODE_W-1:0] {
        BR_ALWAYS = 4'd0,  BR_NEVER = 4'd1,
        BR_HI     = 4'd2,  BR_LS    = 4'd3,
        BR_CC     = 4'd4,  BR_CS    = 4'd5,
        BR_NE     = 4'd6,  BR_EQ    = 4'd7,
        BR_VC     = 4'd8,  BR_VS    = 4'd9,
        BR_PL     = 4'd10, BR_MI    = 4'd11,
        BR_GE     = 4'd12, BR_LT    = 4'd13,
        BR_GT     = 4'd14, BR_LE    = 4'd15
    } brc_code_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } brc_flags_t;
endpackage

// File: rtl/brc_terms.sv
// Computes, for each selector pair, the truth of its even (non-inverted) member.
module brc_terms
    import brc_pkg::*;
(
    input  brc_flags_t       flags,
    output logic [PAIRS-1:0] pair_true
);
    logic sgn_lt;

    always_comb begin
        sgn_lt       = flags.n ^ flags.v;
        pair_true    = '0;
        pair_true[0] = 1'b1;                          // always
        pair_true[1] = ~(flags.c | flags.z);          // unsigned higher
        pair_true[2] = ~flags.c;                      // carry clear
        pair_true[3] = ~flags.z;                      // not equal
        pair_true[4] = ~flags.v;                      // overflow clear
        pair_true[5] = ~flags.n;                      // plus
        pair_true[6] = ~sgn_lt;                       // signed greater-or-equal
        pair_true[7] = ~(flags.z | sgn_lt);           // signed greater
    end
endmodule

// File: rtl/brc_sense.sv
// Picks one pair's term and applies the sense bit.
module brc_sense #(
    parameter int NPAIR = 8,
    localparam int SEL_W = $clog2(NPAIR)
) (
    input  logic [NPAIR-1:0] pair_true,
    input  logic [SEL_W-1:0] pair_sel,
    input  logic             invert,
    output logic             take
);
    always_comb begin
        take = pair_true[pair_sel] ^ invert;
    end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import brc_pkg::*;
(
    input  logic [CODE_W-1:0] cond_i,
    input  logic              n_i,
    input  logic              z_i,
    input  logic              v_i,
    input  logic              c_i,
    output logic              take_o
);
    brc_flags_t       flags_d;
    logic [PAIRS-1:0] pair_true_d;

    always_comb begin
        flags_d.n = n_i;
        flags_d.z = z_i;
        flags_d.v = v_i;
        flags_d.c = c_i;
    end

    brc_terms u_terms (
        .flags     (flags_d),
        .pair_true (pair_true_d)
    );

    brc_sense #(.NPAIR(PAIRS)) u_sense (
        .pair_true (pair_true_d),
        .pair_sel  (cond_i[CODE_W-1:1]),
        .invert    (cond_i[0]),
        .take      (take_o)
    );
endmodule

// File: rtl/brc_checker.sv
module brc_checker
    import brc_pkg::*;
(
    input logic [CODE_W-1:0] cond_i,
    input logic              n_i,
    input logic              z_i,
    input logic              v_i,
    input logic              c_i,
    input logic              take_o
);
    always_comb begin
        a_r1_always: assert (!(cond_i == BR_ALWAYS) || take_o)
            else $error("R1 always code not taken");
        a_r1_never: assert (!(cond_i == BR_NEVER) || !take_o)
            else $error("R1 never code taken");
        a_r2_cs: assert (!(cond_i == BR_CS && take_o) || c_i)
            else $error("R2 carry-set taken with C=0");
        a_r3_eq: assert (!(cond_i == BR_EQ && take_o) || z_i)
            else $error("R3 equal taken with Z=0");
        a_r6_hi: assert (!(cond_i == BR_HI && take_o) || (!c_i && !z_i))
            else $error("R6 higher taken with C or Z set");
        a_r7_lt: assert (!(cond_i == BR_LT && take_o) || (n_i != v_i))
            else $error("R7 less taken with N equal V");
        a_r8_le: assert (!(cond_i == BR_LE && !take_o) || !z_i)
            else $error("R8 less-or-equal not taken with Z=1");
    end
endmodule

bind branch_cond_eval brc_checker u_chk (
    .cond_i (cond_i),
    .n_i    (n_i),
    .z_i    (z_i),
    .v_i    (v_i),
    .c_i    (c_i),
    .take_o (take_o)
);

// File: tb/branch_cond_eval_test.sv
module branch_cond_eval_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cond_i = 4'd0;
    logic       n_i = 1'b0, z_i = 1'b0, v_i = 1'b0, c_i = 1'b0;
    logic       take_o;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    branch_cond_eval uut (
        .cond_i (cond_i), .n_i (n_i), .z_i (z_i),
        .v_i (v_i), .c_i (c_i), .take_o (take_o)
    );

    function automatic logic exp_take(input logic [3:0] k,
                                      input logic n, input logic z,
                                      input logic v, input logic c);
        case (k)
            4'd0:  return 1'b1;
            4'd1:  return 1'b0;
            4'd2:  return !(c || z);
            4'd3:  return c || z;
            4'd4:  return !c;
            4'd5:  return c;
            4'd6:  return !z;
            4'd7:  return z;
            4'd8:  return !v;
            4'd9:  return v;
            4'd10: return !n;
            4'd11: return n;
            4'd12: return n == v;
            4'd13: return n != v;
            4'd14: return !z && (n == v);
            default: return z || (n != v);
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] k);
        case (k)
            4'd0, 4'd1:   return "R1";
            4'd4, 4'd5:   return "R2";
            4'd6, 4'd7:   return "R3";
            4'd10, 4'd11: return "R4";
            4'd8, 4'd9:   return "R5";
            4'd2, 4'd3:   return "R6";
            4'd12, 4'd13: return "R7";
            default:      return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cond=%0d nzvc=%b%b%b%b actual=%b expected=%b",
                     req, cond_i, n_i, z_i, v_i, c_i, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] k, input logic [3:0] f);
        cond_i = k;
        {n_i, z_i, v_i, c_i} = f;
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R10: valid while reset is held, before any clock edge
        apply(4'd0, 4'b0000);
        check("R10", take_o, 1'b1);
        apply(4'd1, 4'b0000);
        check("R10", take_o, 1'b0);
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // exhaustive sweep: R1..R8 per code, R9 pair inversion
        for (int k = 0; k < 16; k++) begin
            for (int f = 0; f < 16; f++) begin
                @(negedge clk);
                apply(4'(k), 4'(f));
                check(req_of(4'(k)), take_o,
                      exp_take(4'(k), f[3], f[2], f[1], f[0]));
                begin
                    logic first;
                    first = take_o;
                    apply(4'(k) ^ 4'd1, 4'(f));
                    check("R9", take_o, !first);
                end
            end
        end

        // directed corners: unsigned vs signed ordering after a compare
        @(negedge clk);
        apply(4'd2, 4'b0100);  check("R6", take_o, 1'b0); // equal: not higher
        apply(4'd3, 4'b0001);  check("R6", take_o, 1'b1); // borrow: lower-or-same
        apply(4'd12, 4'b1010); check("R7", take_o, 1'b1); // N=V=1: GE
        apply(4'd13, 4'b0010); check("R7", take_o, 1'b1); // V only: less
        apply(4'd14, 4'b0100); check("R8", take_o, 1'b0); // Z: not greater
        apply(4'd15, 4'b1000); check("R8", take_o, 1'b1); // N only: LE

        // random: several input changes between edges (R10)
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] k;
            logic [3:0] f;
            if (i % 4 == 0) @(negedge clk);
            k = 4'($urandom);
            f = 4'($urandom);
            apply(k, f);
            check((i % 4 == 0) ? req_of(k) : "R10", take_o,
                  exp_take(k, f[3], f[2], f[1], f[0]));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule